// File: doc/BRIEF.md
# FIFO-Buffered Clocked Serial Port

This block is a clocked serial port that moves a burst of bytes out of, and back into, a small on-chip buffer. The host fills up to eight byte slots and a transfer count through a simple register port, selects the bit order, the clock source and the gating options, then pulses `start`. The port shifts each slot out on `so` and captures `si` at the same time. Each received byte replaces the slot it came from, so the buffer holds the incoming bytes when the burst ends.

The serial clock is either generated inside the block from a divider of the system clock, or taken from an external `sck_in`. An optional chip-select mode lets the transfer advance only while `cs_n` is low. An optional latch strobe marks the end of a burst. `busy` covers the burst and `done` marks its last bit.

Top module: `sio_burst_port`

## Requirements
- R1: After reset every buffer slot reads zero, `busy`, `done` and `latch` are low and `sck_out` is high. While idle, a host write with `host_addr[3]`=0 stores `host_wdata` into slot `host_addr[2:0]`. A write with `host_addr[3]`=1 sets the burst length to `host_wdata[2:0]`+1 bytes. `host_rdata` always shows slot `host_raddr`.
- R2: Host writes to slots or to the length register are ignored while `busy` is high.
- R3: A `start` pulse taken while idle transfers slots 0 up to length-1 in order. After the burst, each of those slots holds the byte received while it was being sent. Slots beyond the length are unchanged.
- R4: With `cfg_lsb_first`=0 each byte is sent and received bit 7 first. With `cfg_lsb_first`=1 it goes bit 0 first.
- R5: In internal-clock mode (`cfg_ext_clk`=0) the half period H equals `cfg_half`, raised to 4 when it is smaller. `sck_out` idles high. Its first falling edge comes H cycles after the start edge, and each half period after that lasts H cycles. `busy` stays high for exactly 16·N·H cycles for N bytes.
- R6: `so` changes only after a falling edge of the serial clock, and `si` is sampled on its rising edge.
- R7: In external-clock mode (`cfg_ext_clk`=1) `sck_oe` is low, and the synchronised edges of `sck_in` clock the transfer with the same edge roles as R6.
- R8: With `cfg_cs_mode`=1 and `cs_n` high, no bit moves, the internal clock holds its level and `so_oe` is low. The burst resumes once `cs_n` goes low. With `cfg_cs_mode`=0, `so_oe` is high.
- R9: `done` is a one-cycle pulse in the first cycle after `busy` falls.
- R10: With `cfg_latch_en`=1, `latch` goes high together with `done` and stays high for 2·H cycles, which is one serial clock period. With `cfg_latch_en`=0 it stays low.
- R11: A `start` pulse while `busy` is high is ignored and does not restart the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Write address: bit 3 selects the length register, bits 2:0 the slot |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 3 | Slot to read |
| host_rdata | output | 8 | Content of the selected slot |
| start | input | 1 | Begin a burst (one cycle) |
| cfg_lsb_first | input | 1 | 1 = bit 0 first, 0 = bit 7 first |
| cfg_ext_clk | input | 1 | 1 = clock taken from sck_in |
| cfg_cs_mode | input | 1 | 1 = transfer gated by cs_n |
| cfg_latch_en | input | 1 | Enable the end-of-burst strobe |
| cfg_half | input | 8 | Requested internal half period in system clocks |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internal serial clock |
| sck_oe | output | 1 | Drive enable for sck_out |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for so |
| cs_n | input | 1 | Chip select, active low |
| latch | output | 1 | End-of-burst strobe |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst finished (one cycle) |

## Verification
A host slot write and a `start` pulse can land in the same cycle. The bench provokes this by driving both on one edge while the port is idle. The judgement is that the new byte is what goes out on `so` for slot 0, as compared bit by bit by the cycle model. A second collision comes from writes and a repeated `start` issued in the middle of a running burst. These are judged by the burst length still matching the old length register, and by the targeted slot reading back unchanged.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // One serial clock edge event, as seen by the sequencer
  typedef struct packed {
    logic rise;
    logic fall;
  } sio_evt_t;

  // Half period actually used: request clamped to a floor
  function automatic int eff_half(input int req, input int floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // Cycles of one burst for n bytes of bits_per_byte at half period h
  function automatic int burst_cycles(input int n, input int bits_per_byte, input int h);
    return 2 * bits_per_byte * n * h;
  endfunction

endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             gate,
  input  logic             ext_mode,
  input  logic [DIV_W-1:0] half_eff,
  input  logic             sck_in,
  output logic             sck_int,
  output sio_pkg::sio_evt_t evt
);
  logic [DIV_W-1:0] hc;
  logic             sck_q;
  logic [2:0]       sync_q;
  logic             int_active;
  logic             tick;
  logic             ext_active;
  logic             ext_rise;
  logic             ext_fall;

  assign int_active = run && gate && !ext_mode;
  assign tick       = int_active && (hc == half_eff - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc    <= '0;
      sck_q <= 1'b1;
    end else if (restart) begin
      hc    <= '0;
      sck_q <= 1'b1;
    end else if (int_active) begin
      if (tick) begin
        hc    <= '0;
        sck_q <= ~sck_q;
      end else begin
        hc <= hc + 1'b1;
      end
    end else if (!run) begin
      sck_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[1:0], sck_in};
  end

  assign ext_active = run && gate && ext_mode;
  assign ext_rise   = ext_active && sync_q[1] && !sync_q[2];
  assign ext_fall   = ext_active && !sync_q[1] && sync_q[2];

  assign sck_int  = sck_q;
  assign evt.rise = ext_mode ? ext_rise : (tick && !sck_q);
  assign evt.fall = ext_mode ? ext_fall : (tick && sck_q);
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          capture,
  input  logic          lsb_first,
  input  logic [DW-1:0] load_val,
  input  logic          si_bit,
  output logic          tx_bit,
  output logic [DW-1:0] rx_next
);
  logic [DW-1:0] tx_q;
  logic [DW-1:0] rx_q;

  always_comb begin
    if (lsb_first) rx_next = {si_bit, rx_q[DW-1:1]};
    else           rx_next = {rx_q[DW-2:0], si_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load)       tx_q <= load_val;
      else if (shift) tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
      if (capture)    rx_q <= rx_next;
    end
  end

  assign tx_bit = lsb_first ? tx_q[0] : tx_q[DW-1];
endmodule

// File: rtl/sio_buffer.sv
module sio_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [AW-1:0] host_waddr,
  input  logic [DW-1:0] host_wdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [DW-1:0] eng_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] tx_addr,
  output logic [DW-1:0] tx_data
);
  logic [DW-1:0]    slot [DEPTH];
  logic [DEPTH-1:0] hsel;
  logic [DEPTH-1:0] esel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign hsel[g] = host_we && (host_waddr == AW'(g));
    assign esel[g] = eng_we && (eng_addr == AW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (esel[i])      slot[i] <= eng_data;
        else if (hsel[i]) slot[i] <= host_wdata;
      end
    end
  end

  assign rd_data = slot[rd_addr];
  assign tx_data = slot[tx_addr];
endmodule

// File: rtl/sio_burst_port.sv
module sio_burst_port #(
  parameter int DW       = 8,
  parameter int DEPTH    = 8,
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_we,
  input  logic [$clog2(DEPTH):0]     host_addr,
  input  logic [DW-1:0]              host_wdata,
  input  logic [$clog2(DEPTH)-1:0]   host_raddr,
  output logic [DW-1:0]              host_rdata,
  input  logic                       start,
  input  logic                       cfg_lsb_first,
  input  logic                       cfg_ext_clk,
  input  logic                       cfg_cs_mode,
  input  logic                       cfg_latch_en,
  input  logic [DIV_W-1:0]           cfg_half,
  input  logic                       sck_in,
  output logic                       sck_out,
  output logic                       sck_oe,
  input  logic                       si,
  output logic                       so,
  output logic                       so_oe,
  input  logic                       cs_n,
  output logic                       latch,
  output logic                       busy,
  output logic                       done
);
  import sio_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int BW = $clog2(DW);
  localparam int LW = DIV_W + 1;

  logic [DIV_W-1:0] half_eff;
  logic [AW-1:0]    cnt_m1;
  logic [AW-1:0]    byte_idx;
  logic [BW-1:0]    bit_cnt;
  logic [LW-1:0]    latch_cnt;
  logic [1:0]       cs_q;
  logic [1:0]       si_q;
  logic             gate_open;
  logic             start_ok;
  logic             host_ok;
  logic             last_bit;
  logic             last_byte;
  logic             byte_end;
  logic             rise_evt;
  logic             fall_evt;
  logic             load_tx;
  logic             shift_tx;
  logic             sck_int;
  logic [DW-1:0]    tx_data;
  logic [DW-1:0]    rx_next;
  sio_evt_t         evt;

  assign half_eff = DIV_W'(eff_half(int'(cfg_half), MIN_HALF));

  // Synchronisers for the asynchronous serial inputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 2'b11;
      si_q <= 2'b00;
    end else begin
      cs_q <= {cs_q[0], cs_n};
      si_q <= {si_q[0], si};
    end
  end

  assign gate_open = !cfg_cs_mode || !cs_q[1];
  assign so_oe     = cfg_cs_mode ? !cs_q[1] : 1'b1;
  assign sck_oe    = !cfg_ext_clk;
  assign sck_out   = sck_int;

  assign start_ok  = start && !busy;
  assign host_ok   = host_we && !busy;
  assign rise_evt  = evt.rise;
  assign fall_evt  = evt.fall;
  assign last_bit  = (bit_cnt == BW'(DW - 1));
  assign last_byte = (byte_idx == cnt_m1);
  assign byte_end  = rise_evt && last_bit;
  assign load_tx   = fall_evt && (bit_cnt == '0);
  assign shift_tx  = fall_evt && (bit_cnt != '0);

  sio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .restart  (start_ok),
    .gate     (gate_open),
    .ext_mode (cfg_ext_clk),
    .half_eff (half_eff),
    .sck_in   (sck_in),
    .sck_int  (sck_int),
    .evt      (evt)
  );

  sio_shifter #(.DW(DW)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_tx),
    .shift     (shift_tx),
    .capture   (rise_evt),
    .lsb_first (cfg_lsb_first),
    .load_val  (tx_data),
    .si_bit    (si_q[1]),
    .tx_bit    (so),
    .rx_next   (rx_next)
  );

  sio_buffer #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_buffer (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_ok && !host_addr[AW]),
    .host_waddr (host_addr[AW-1:0]),
    .host_wdata (host_wdata),
    .eng_we     (byte_end),
    .eng_addr   (byte_idx),
    .eng_data   (rx_next),
    .rd_addr    (host_raddr),
    .rd_data    (host_rdata),
    .tx_addr    (byte_idx),
    .tx_data    (tx_data)
  );

  // Burst length register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_m1 <= '0;
    else if (host_ok && host_addr[AW]) cnt_m1 <= host_wdata[AW-1:0];
  end

  // Burst sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      byte_idx  <= '0;
      bit_cnt   <= '0;
      latch_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (latch_cnt != '0) latch_cnt <= latch_cnt - 1'b1;
      if (start_ok) begin
        busy     <= 1'b1;
        byte_idx <= '0;
        bit_cnt  <= '0;
      end else if (busy && rise_evt) begin
        if (last_bit) begin
          bit_cnt <= '0;
          if (last_byte) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            latch_cnt <= cfg_latch_en ? LW'({half_eff, 1'b0}) : '0;
          end else begin
            byte_idx <= byte_idx + 1'b1;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign latch = (latch_cnt != '0);
endmodule

// File: rtl/sio_burst_port_chk.sv
module sio_burst_port_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          latch,
  input logic          sck_out,
  input logic          cfg_ext_clk,
  input logic          cfg_lsb_first,
  input logic          so,
  input logic          rise_evt,
  input logic          fall_evt,
  input logic          gate_open,
  input logic          host_we,
  input logic [AW-1:0] cnt_m1,
  input logic [AW-1:0] byte_idx
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ext_clk && !busy) |-> sck_out); // R5
  AST_SO_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_evt) |=> ((so == $past(so)) || (cfg_lsb_first != $past(cfg_lsb_first)))); // R6
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt)); // R6
  AST_GATE_FREEZES_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !gate_open) |=> $stable(sck_out)); // R8
  AST_COUNT_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_we) |=> $stable(cnt_m1)); // R2
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (byte_idx <= cnt_m1)); // R3
  AST_LATCH_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch) |-> done); // R10
endmodule

bind sio_burst_port sio_burst_port_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done          (done),
  .latch         (latch),
  .sck_out       (sck_out),
  .cfg_ext_clk   (cfg_ext_clk),
  .cfg_lsb_first (cfg_lsb_first),
  .so            (so),
  .rise_evt      (rise_evt),
  .fall_evt      (fall_evt),
  .gate_open     (gate_open),
  .host_we       (host_we),
  .cnt_m1        (cnt_m1),
  .byte_idx      (byte_idx)
);

// File: tb/tb_sio_burst_port.sv
module tb_sio_burst_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [2:0] host_raddr = '0;
  logic [7:0] host_rdata;
  logic       start = 1'b0;
  logic       cfg_lsb_first = 1'b0, cfg_ext_clk = 1'b0, cfg_cs_mode = 1'b0, cfg_latch_en = 1'b0;
  logic [7:0] cfg_half = 8'd4;
  logic       sck_in = 1'b1;
  logic       sck_out, sck_oe, so, so_oe, latch, busy, done;
  logic       cs_n = 1'b1;
  logic       si;
  logic       si_model = 1'b0, si_ext = 1'b0, si_sel_ext = 1'b0;

  assign si = si_sel_ext ? si_ext : si_model;

  sio_burst_port dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .start(start), .cfg_lsb_first(cfg_lsb_first), .cfg_ext_clk(cfg_ext_clk),
    .cfg_cs_mode(cfg_cs_mode), .cfg_latch_en(cfg_latch_en), .cfg_half(cfg_half),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .si(si), .so(so),
    .so_oe(so_oe), .cs_n(cs_n), .latch(latch), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vec = 0;
  int bad = 0;
  bit finished = 1'b0;
  int done_cnt = 0;
  logic [7:0] exp_mem [8];

  // Reference model state for internal-clock bursts
  int m = 0;
  bit model_on = 1'b0;
  bit model_arm = 1'b0;
  int mN = 1, mH = 4;
  bit mLsb = 1'b0, mEn = 1'b0;
  logic [7:0] mtx [8];
  logic [7:0] mrx [8];

  function automatic int half_of(int req);
    return (req < 4) ? 4 : req;
  endfunction

  function automatic logic bit_at(logic [7:0] v, int b, bit lsb);
    return lsb ? v[b] : v[7 - b];
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model timebase: m counts edges since the accepted start edge
  always @(posedge clk) begin
    if (model_arm && start) begin
      m <= 0;
      model_on <= 1'b1;
      model_arm <= 1'b0;
    end else begin
      m <= m + 1;
      if (model_on && m >= 16 * mN * mH + 2 * mH + 2) model_on <= 1'b0;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    int tot, b;
    logic eb, ed, el, es, eso;
    if (done) done_cnt++;
    if (model_on) begin
      tot = 16 * mN * mH;
      eb  = (m < tot);
      ed  = (m == tot);
      el  = mEn && (m >= tot) && (m < tot + 2 * mH);
      es  = (m >= tot) ? 1'b1 : (((m / mH) % 2) == 0);
      check(busy == eb && done == ed && latch == el && sck_out == es && so_oe,
            "R5/R9/R10 busy,done,latch,sck", {busy, done, latch, sck_out},
            {eb, ed, el, es});
      if (eb && m >= mH) begin
        b   = (m / mH - 1) / 2;
        eso = bit_at(mtx[b / 8], b % 8, mLsb);
        check(so == eso, "R4 R6 so bit", so, eso);
        si_model = bit_at(mrx[b / 8], b % 8, mLsb);
      end
    end
  end

  task automatic host_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic check_mem(string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      host_raddr = 3'(i);
      #1;
      check(host_rdata == exp_mem[i], tag, host_rdata, exp_mem[i]);
    end
  endtask

  task automatic run_int(int n, bit lsb, int half, bit en, bit wr_cnt,
                         bit same_wr, logic [7:0] sval, logic [7:0] seed);
    if (wr_cnt) host_write(4'h8, 8'(n - 1));
    @(negedge clk);
    cfg_lsb_first = lsb; cfg_half = 8'(half); cfg_latch_en = en;
    cfg_ext_clk = 1'b0; cfg_cs_mode = 1'b0; si_sel_ext = 1'b0;
    mN = n; mH = half_of(half); mLsb = lsb; mEn = en;
    if (same_wr) begin
      exp_mem[0] = sval;
      host_we = 1'b1; host_addr = 4'h0; host_wdata = sval;
    end
    for (int i = 0; i < 8; i++) begin
      mtx[i] = exp_mem[i];
      mrx[i] = seed ^ 8'(i * 37);
    end
    start = 1'b1; model_arm = 1'b1;
    @(negedge clk);
    start = 1'b0; host_we = 1'b0;
    repeat (16 * n * mH + 2 * mH + 6) @(negedge clk);
    for (int i = 0; i < n; i++) exp_mem[i] = mrx[i];
  endtask

  initial begin
    for (int i = 0; i < 8; i++) exp_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && latch == 0 && sck_out == 1, "R1 reset outputs",
          {busy, done, latch, sck_out}, 4'b0001);
    check_mem("R1 reset slots");

    // R1: fill the buffer while idle
    for (int i = 0; i < 8; i++) begin
      exp_mem[i] = 8'h11 * 8'(i + 1) ^ 8'h5A;
      host_write(4'(i), exp_mem[i]);
    end
    check_mem("R1 readback");

    // R3 R4 R5 R10: three bytes, bit 7 first, latch on
    run_int(3, 1'b0, 4, 1'b1, 1'b1, 1'b0, 8'h00, 8'hC3);
    check_mem("R3 after 3-byte burst");

    // R4 R5: eight bytes, bit 0 first, clamped half period, latch off
    run_int(8, 1'b1, 2, 1'b0, 1'b1, 1'b0, 8'h00, 8'h96);
    check_mem("R3 R4 after 8-byte lsb burst");

    // R2 R11: writes and a second start during a one-byte burst
    fork
      run_int(1, 1'b0, 6, 1'b1, 1'b1, 1'b0, 8'h00, 8'h3E);
      begin
        repeat (30) @(negedge clk);
        host_write(4'h3, 8'hEE);
        host_write(4'h8, 8'h05);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
    join
    @(negedge clk);
    host_raddr = 3'd3;
    #1;
    check(host_rdata == exp_mem[3], "R2 slot write while busy", host_rdata, exp_mem[3]);
    check_mem("R3 after one-byte burst");

    // Same-cycle slot write and start; length must still be one byte (R2)
    run_int(1, 1'b0, 5, 1'b0, 1'b0, 1'b1, 8'h3C, 8'h71);
    check_mem("R1 R3 write in start cycle");

    // R7: external clock, two bytes, bit 7 first
    begin
      logic [7:0] rxe [2];
      logic [7:0] txe [2];
      int d0;
      rxe[0] = 8'hB4; rxe[1] = 8'h2D;
      txe[0] = exp_mem[0]; txe[1] = exp_mem[1];
      host_write(4'h8, 8'h01);
      @(negedge clk);
      cfg_ext_clk = 1'b1; cfg_lsb_first = 1'b0; cfg_latch_en = 1'b0;
      si_sel_ext = 1'b1; d0 = done_cnt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(sck_oe == 1'b0, "R7 sck_oe low", sck_oe, 0);
      for (int b = 0; b < 16; b++) begin
        sck_in = 1'b0; si_ext = bit_at(rxe[b / 8], b % 8, 1'b0);
        repeat (6) @(negedge clk);
        check(so == bit_at(txe[b / 8], b % 8, 1'b0), "R7 R6 ext so bit", so,
              bit_at(txe[b / 8], b % 8, 1'b0));
        sck_in = 1'b1;
        repeat (6) @(negedge clk);
      end
      check(busy == 1'b0 && done_cnt == d0 + 1, "R7 R9 ext burst end",
            {busy, 4'(done_cnt - d0)}, 1);
      exp_mem[0] = rxe[0]; exp_mem[1] = rxe[1];
      check_mem("R7 R3 ext readback");
    end

    // R8: chip-select gating with the internal clock
    begin
      @(negedge clk);
      cfg_ext_clk = 1'b0; cfg_cs_mode = 1'b1; cfg_half = 8'd4;
      si_sel_ext = 1'b1; si_ext = 1'b1; cs_n = 1'b1;
      host_write(4'h8, 8'h00);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (40) @(negedge clk);
      check(busy == 1 && sck_out == 1 && so_oe == 0, "R8 held by cs_n",
            {busy, sck_out, so_oe}, 3'b110);
      check_mem("R8 slots untouched while gated");
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      check(so_oe == 1'b1, "R8 so_oe with cs_n low", so_oe, 1);
      repeat (80) @(negedge clk);
      check(busy == 1'b0, "R8 burst completes", busy, 0);
      exp_mem[0] = 8'hFF;
      check_mem("R8 R3 gated readback");
      cfg_cs_mode = 1'b0; cs_n = 1'b1;
      @(negedge clk);
      check(so_oe == 1'b1, "R8 so_oe in plain mode", so_oe, 1);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule